// File: doc/BRIEF.md
# Cartridge Bank-Switch Latch

This block is the bank mapper of a multi-game cartridge. The host selects the mapper with an active-low select strobe, which is qualified by the host address strobe. During a write cycle it drives a bank number on the low data bits. The mapper holds that number and drives it onto the high ROM address lines, so the chosen game image appears in the cartridge window.

The bank number is taken when the select strobe is released, on its rising edge. This works because the host keeps the write data on the bus until after the select has gone inactive.

The block does not clock any flop from the strobe itself. The select strobe, the write strobe and the data bits each pass through a synchroniser clocked by the system clock. The trailing edge is found in that clock domain. A shadow register follows the data while the select is low, so the captured value is the data that was present inside the select window.

Top module: `cart_bank_latch`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `rom_hi` equals the reset bank, which defaults to 0 (first image).
- R2: A write cycle with data d on `hdata` loads d into `rom_hi`. Bit i of `hdata` goes to bit i of `rom_hi`, and `rom_hi[0]` drives ROM address bit 21, up to `rom_hi[3]` on bit 24. Every value from 0 to 15 is captured.
- R3: The new bank appears at the `SYNC_STAGES+1`-th rising clock edge after `csel_n` goes high (the third edge by default). It does not appear on any earlier edge.
- R4: A select window in which `hwr_n` stays high (a read) leaves `rom_hi` unchanged.
- R5: If `hdata` changes at the same moment `csel_n` is released, the captured bank is still the value held while the select was low.
- R6: While `csel_n` is high, activity on `hwr_n` and `hdata` has no effect on `rom_hi`.
- R7: A write strobe that is low for only part of the select window, and goes high again before the select is released, still counts as a write.
- R8: While `csel_n` stays low, `rom_hi` does not change; a capture happens only on the trailing edge. Between captures `rom_hi` is stable.
- R9: A reset applied in the middle of a write window cancels that capture. After reset is released with the select high, `rom_hi` stays at the reset bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the strobes |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| csel_n | input | 1 | Active-low mapper select strobe from the host |
| hwr_n | input | 1 | Active-low host write strobe |
| hdata | input | DATA_W (4) | Low host data bits carrying the bank number |
| rom_hi | output | DATA_W (4) | Latched bank, drives ROM address bits 21 to 24 |

## Verification
The only timed result is the bank update, which is due on the third rising clock edge after the select goes high: two synchroniser edges, then one edge in which the trailing edge is detected and the value is committed. The bench drives every input on the falling clock edge. It releases the select and checks `rom_hi` one half-period after the second rising edge, where the old bank must still be present. It checks again after the third rising edge, where the new bank must be present. Checks for reads, idle-bus noise and a long-held select are made after the same three-edge window has passed, so a late update cannot escape them.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
   // Default widths and depths shared by the latch modules
   parameter int unsigned CBL_DATA_W      = 4;
   parameter int unsigned CBL_SYNC_STAGES = 2;
   parameter int unsigned CBL_ROM_LSB     = 21;

   // Idle levels of the synchronised strobes
   typedef struct packed {
      logic sel_n;
      logic wr_n;
   } cbl_strobe_t;

   localparam cbl_strobe_t CBL_STROBE_IDLE = '{sel_n: 1'b1, wr_n: 1'b1};
endpackage

// File: rtl/cbl_sync.sv
module cbl_sync #(
   parameter int unsigned         W       = 6,
   parameter int unsigned         STAGES  = 2,
   parameter logic [W-1:0]        RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   // Elaboration checks
   if (STAGES < 2) begin : g_bad_stages
      $error("cbl_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("cbl_sync: W must be at least 1");
   end

   logic [W-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= RST_VAL;
            else        pipe[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= RST_VAL;
            else        pipe[s] <= pipe[s-1];
         end
      end
   end

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/cbl_capture.sv
module cbl_capture #(
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_sel_n,
   input  logic              s_wr_n,
   input  logic [DATA_W-1:0] s_data,
   output logic              commit_o,
   output logic [DATA_W-1:0] cap_data_o
);
   logic              sel_q;
   logic              wr_seen_q;
   logic [DATA_W-1:0] shadow_q;
   logic              window_open;

   // The window opens on the cycle the synchronised select first reads low
   assign window_open = sel_q & ~s_sel_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q     <= 1'b1;
         wr_seen_q <= 1'b0;
         shadow_q  <= '0;
      end else begin
         sel_q <= s_sel_n;
         if (!s_sel_n) begin
            shadow_q  <= s_data;
            wr_seen_q <= (window_open ? 1'b0 : wr_seen_q) | ~s_wr_n;
         end else begin
            wr_seen_q <= 1'b0;
         end
      end
   end

   // Trailing edge of the select, qualified by a write inside the window
   assign commit_o   = s_sel_n & ~sel_q & wr_seen_q;
   assign cap_data_o = shadow_q;
endmodule

// File: rtl/cbl_bank_reg.sv
module cbl_bank_reg #(
   parameter int unsigned          DATA_W     = 4,
   parameter logic [DATA_W-1:0]    RESET_BANK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_i,
   input  logic [DATA_W-1:0] cap_data_i,
   output logic [DATA_W-1:0] bank_o
);
   logic [DATA_W-1:0] bank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bank_q <= RESET_BANK;
      else if (commit_i) bank_q <= cap_data_i;
   end

   assign bank_o = bank_q;

   // R1
   reset_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> bank_q == RESET_BANK);

   // R8
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> $stable(bank_q));
endmodule

// File: rtl/cart_bank_latch.sv
module cart_bank_latch
   import cbl_pkg::*;
#(
   parameter int unsigned          DATA_W      = CBL_DATA_W,
   parameter int unsigned          SYNC_STAGES = CBL_SYNC_STAGES,
   parameter int unsigned          ROM_LSB     = CBL_ROM_LSB,
   parameter logic [DATA_W-1:0]    RESET_BANK  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csel_n,
   input  logic              hwr_n,
   input  logic [DATA_W-1:0] hdata,
   output logic [DATA_W-1:0] rom_hi
);
   localparam int unsigned BUS_W  = DATA_W + 2;
   localparam int unsigned ROM_MSB = ROM_LSB + DATA_W - 1;
   localparam logic [BUS_W-1:0] BUS_IDLE = {CBL_STROBE_IDLE, {DATA_W{1'b0}}};

   if (DATA_W < 1 || DATA_W > 8) begin : g_bad_data_w
      $error("cart_bank_latch: DATA_W out of range");
   end
   if (ROM_MSB > 31) begin : g_bad_rom_pos
      $error("cart_bank_latch: bank bits exceed a 32-bit ROM address");
   end

   logic [BUS_W-1:0]  raw_bus;
   logic [BUS_W-1:0]  syn_bus;
   cbl_strobe_t       syn_strb;
   logic [DATA_W-1:0] syn_data;
   logic              commit;
   logic [DATA_W-1:0] cap_data;

   assign raw_bus  = {csel_n, hwr_n, hdata};
   assign syn_strb = syn_bus[BUS_W-1 -: 2];
   assign syn_data = syn_bus[DATA_W-1:0];

   cbl_sync #(
      .W       (BUS_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (BUS_IDLE)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_bus),
      .q_o   (syn_bus)
   );

   cbl_capture #(
      .DATA_W (DATA_W)
   ) i_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .s_sel_n    (syn_strb.sel_n),
      .s_wr_n     (syn_strb.wr_n),
      .s_data     (syn_data),
      .commit_o   (commit),
      .cap_data_o (cap_data)
   );

   cbl_bank_reg #(
      .DATA_W     (DATA_W),
      .RESET_BANK (RESET_BANK)
   ) i_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit_i   (commit),
      .cap_data_i (cap_data),
      .bank_o     (rom_hi)
   );

   // R2
   load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> rom_hi == $past(cap_data));

   // R3
   trailing_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> $rose(syn_strb.sel_n));
endmodule

// File: tb/test_cart_bank_latch.sv
`timescale 1ns/1ps
module test_cart_bank_latch;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       csel_n = 1'b1;
   logic       hwr_n = 1'b1;
   logic [3:0] hdata = 4'h0;
   logic [3:0] rom_hi;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   cart_bank_latch i_cart_bank_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .csel_n (csel_n),
      .hwr_n  (hwr_n),
      .hdata  (hdata),
      .rom_hi (rom_hi)
   );

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: rom_hi=%h expected %h", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Release the select at a falling edge, then check old value after
   // two rising edges and new value after the third.
   task automatic release_and_check(input string req, input logic [3:0] old_v,
                                    input logic [3:0] new_v);
      csel_n = 1'b1;
      hwr_n  = 1'b1;
      ticks(2);
      chk(req, rom_hi, old_v);
      ticks(1);
      chk(req, rom_hi, new_v);
   endtask

   task automatic write_bank(input string req, input logic [3:0] old_v,
                             input logic [3:0] d, input int low_cycles);
      @(negedge clk);
      csel_n = 1'b0;
      hwr_n  = 1'b0;
      hdata  = d;
      ticks(low_cycles);
      release_and_check(req, old_v, d);
   endtask

   task automatic t_reset;
      ticks(3);
      chk("R1", rom_hi, 4'h0);
      rst_n = 1'b1;
      ticks(1);
      chk("R1", rom_hi, 4'h0);
   endtask

   task automatic t_basic;
      // R2 R3 latency and value
      write_bank("R3", 4'h0, 4'h5, 3);
      write_bank("R2", 4'h5, 4'hF, 4);
      write_bank("R2", 4'hF, 4'h0, 3);
      write_bank("R2", 4'h0, 4'h5, 3);
   endtask

   task automatic t_read;
      // R4 read window leaves bank alone
      @(negedge clk);
      csel_n = 1'b0;
      hwr_n  = 1'b1;
      hdata  = 4'hA;
      ticks(4);
      csel_n = 1'b1;
      ticks(6);
      chk("R4", rom_hi, 4'h5);
   endtask

   task automatic t_data_at_release;
      // R5 data changes together with the select release
      @(negedge clk);
      csel_n = 1'b0;
      hwr_n  = 1'b0;
      hdata  = 4'h9;
      ticks(3);
      csel_n = 1'b1;
      hwr_n  = 1'b1;
      hdata  = 4'h6;
      ticks(6);
      chk("R5", rom_hi, 4'h9);
   endtask

   task automatic t_idle_noise;
      // R6 wr/data activity with select high
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         hwr_n = i[0];
         hdata = 4'(i * 3);
      end
      hwr_n = 1'b1;
      ticks(6);
      chk("R6", rom_hi, 4'h9);
   endtask

   task automatic t_short_wr;
      // R7 write strobe low only at the start of the window
      @(negedge clk);
      csel_n = 1'b0;
      hwr_n  = 1'b0;
      hdata  = 4'h3;
      ticks(2);
      hwr_n = 1'b1;
      ticks(3);
      release_and_check("R7", 4'h9, 4'h3);
   endtask

   task automatic t_hold_low;
      // R8 no change while select stays low
      @(negedge clk);
      csel_n = 1'b0;
      hwr_n  = 1'b0;
      hdata  = 4'hC;
      ticks(10);
      chk("R8", rom_hi, 4'h3);
      release_and_check("R8", 4'h3, 4'hC);
   endtask

   task automatic t_reset_mid;
      // R9 reset in the middle of a write window
      @(negedge clk);
      csel_n = 1'b0;
      hwr_n  = 1'b0;
      hdata  = 4'h7;
      ticks(3);
      rst_n = 1'b0;
      ticks(1);
      chk("R9", rom_hi, 4'h0);
      csel_n = 1'b1;
      hwr_n  = 1'b1;
      ticks(2);
      rst_n = 1'b1;
      ticks(6);
      chk("R9", rom_hi, 4'h0);
      write_bank("R9", 4'h0, 4'hB, 3);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: cycles=%0d expected completion", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      t_reset;
      t_basic;
      t_read;
      t_data_at_release;
      t_idle_noise;
      t_short_wr;
      t_hold_low;
      t_reset_mid;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule